// File: doc/BRIEF.md
# Register-Programmable PWM Generator

This block produces a single pulse-width-modulated square wave for driving a DC motor stage. Software programs it through a small synchronous slave port with three registers: the cycle length in clock ticks, the low-time count, and a run bit. A wide counter clocked by the system clock sweeps each cycle. A comparator sets the output from the count: the output is low while the count is at or below the low-time value and high after that.

Motors of this kind stall and heat up at very small drive levels. For that reason the block never stores a low-time value under a floor set by a parameter. Any smaller value written is replaced by the floor plus one, and software reads back the value that was stored. When a new cycle length or low-time value is written while the wave is running, it waits for the end of the current cycle, so no cycle is ever cut short or stretched. When the run bit is clear, the counter is held at zero and the pin rests high.

Top module: `pwm_gen_top`

## Requirements
- R1: After reset the cycle-length register (offset 0) reads 0, the low-time register (offset 1) reads FLOOR+1, the run register (offset 2) reads 0, and pwm_out is 1.
- R2: Offsets 0, 1 and 2 read back the stored values. The run register returns its value in bit 0 with all upper bits zero. readdata is valid in the clock cycle after the one in which rd is high, and is zero when rd was low. Offset 3 reads 0, and a write to offset 3 changes no register.
- R3: A value written to offset 1 that is below FLOOR is stored as FLOOR+1. A value at or above FLOOR is stored unchanged.
- R4: While the run bit is 0, the counter stays at 0 and pwm_out is 1.
- R5: On the first clock edge at which the run bit is 1 after having been 0, the counter restarts at 0 and captures the current cycle length and low-time.
- R6: While running with a captured cycle length P, the counter goes 0, 1, …, P-1 and then returns to 0, so one cycle lasts P ticks. P=0 behaves like P=1.
- R7: While running, pwm_out is 0 when the count is less than or equal to the captured low-time, and 1 otherwise.
- R8: A cycle length or low-time written while running is captured only when the counter wraps, or at a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| address | input | 2 | Register offset |
| write | input | 1 | Write strobe |
| writedata | input | DATA_W | Write data |
| read | input | 1 | Read strobe |
| readdata | output | DATA_W | Read data, registered |
| pwm_out | output | 1 | PWM output, idle high |

## Verification
A corrupted count or captured value shows up at pwm_out within one cycle length. The falling edge comes at the wrong tick, or the low phase lasts the wrong number of ticks. The bench therefore compares the pin against its own model on every clock. A captured value that changes mid-cycle, instead of at the wrap, changes the pin within the same cycle. A stored low-time under the floor shows up one clock after a read of offset 1, and a missed restart shows up in the first low phase after the run bit rises.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  // Register offsets; the slave port decodes these values.
  typedef enum logic [1:0] {
    OFS_PERIOD = 2'd0,
    OFS_DUTY   = 2'd1,
    OFS_RUN    = 2'd2,
    OFS_SPARE  = 2'd3
  } pwm_ofs_e;

  localparam int ADDR_W = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLOOR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] period_q,
  output logic [DATA_W-1:0] duty_q,
  output logic              run_q
);
  localparam logic [DATA_W-1:0] FLOOR_V = DATA_W'(FLOOR);
  localparam logic [DATA_W-1:0] ONE_V   = DATA_W'(1);

  // Low-time floor: values under the threshold become threshold plus one.
  function automatic logic [DATA_W-1:0] floor_duty(input logic [DATA_W-1:0] v);
    return (v < FLOOR_V) ? (FLOOR_V + ONE_V) : v;
  endfunction

  pwm_ofs_e ofs;
  assign ofs = pwm_ofs_e'(addr);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (ofs)
      OFS_PERIOD: rd_mux = period_q;
      OFS_DUTY:   rd_mux = duty_q;
      OFS_RUN:    rd_mux = {{(DATA_W-1){1'b0}}, run_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= FLOOR_V + ONE_V;
      run_q    <= 1'b0;
    end else if (wr) begin
      unique case (ofs)
        OFS_PERIOD: period_q <= wdata;
        OFS_DUTY:   duty_q   <= floor_duty(wdata);
        OFS_RUN:    run_q    <= wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              active,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] low_max,
  output logic              level
);
  // Low while count <= low_max; idle level is high.
  assign level = active ? (count > low_max) : 1'b1;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic [DATA_W-1:0] period_in,
  input  logic [DATA_W-1:0] duty_in,
  output logic              pwm_level,
  output logic              running,
  output logic [DATA_W-1:0] count,
  output logic              wrap_ev,
  output logic              start_ev,
  output logic [DATA_W-1:0] period_act,
  output logic [DATA_W-1:0] duty_act
);
  localparam logic [DATA_W-1:0] ONE_V = DATA_W'(1);

  // Last count value of a cycle; period 0 acts as period 1.
  function automatic logic [DATA_W-1:0] last_tick(input logic [DATA_W-1:0] p);
    return (p == '0) ? '0 : (p - ONE_V);
  endfunction

  assign start_ev = run_req && !running;
  assign wrap_ev  = run_req && running && (count >= last_tick(period_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      count      <= '0;
      period_act <= '0;
      duty_act   <= '0;
    end else begin
      running <= run_req;
      if (!run_req) begin
        count <= '0;
      end else if (start_ev || wrap_ev) begin
        count      <= '0;
        period_act <= period_in;
        duty_act   <= duty_in;
      end else begin
        count <= count + ONE_V;
      end
    end
  end

  pwm_cmp #(.DATA_W(DATA_W)) u_cmp (
    .active  (running),
    .count   (count),
    .low_max (duty_act),
    .level   (pwm_level)
  );
endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
  import pwm_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLOOR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        address,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  input  logic              read,
  output logic [DATA_W-1:0] readdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] period_q, duty_q;
  logic              run_q;
  logic              running_w, wrap_w, start_w;
  logic [DATA_W-1:0] count_w, period_act_w, duty_act_w;

  pwm_regs #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (address),
    .wr       (write),
    .rd       (read),
    .wdata    (writedata),
    .rdata    (readdata),
    .period_q (period_q),
    .duty_q   (duty_q),
    .run_q    (run_q)
  );

  pwm_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_q),
    .period_in  (period_q),
    .duty_in    (duty_q),
    .pwm_level  (pwm_out),
    .running    (running_w),
    .count      (count_w),
    .wrap_ev    (wrap_w),
    .start_ev   (start_w),
    .period_act (period_act_w),
    .duty_act   (duty_act_w)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int DATA_W = 32,
  parameter int FLOOR  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        address,
  input logic              write,
  input logic              pwm_out,
  input logic              run_q,
  input logic              running,
  input logic              wrap_ev,
  input logic              start_ev,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] period_act,
  input logic [DATA_W-1:0] duty_act,
  input logic [DATA_W-1:0] duty_q
);
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out && count == '0));

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ((period_act == '0) ? (count == '0) : (count < period_act)));

  // R3
  duty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write && address == 2'd1) |=> (duty_q >= DATA_W'(FLOOR)));

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_ev || start_ev) |=> ($stable(period_act) && $stable(duty_act)));

  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (running && count == '0));

  // R7
  low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count <= duty_act) |-> !pwm_out);

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |=> !running);
endmodule

bind pwm_gen_top pwm_gen_chk #(.DATA_W(DATA_W), .FLOOR(FLOOR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .address    (address),
  .write      (write),
  .pwm_out    (pwm_out),
  .run_q      (run_q),
  .running    (running_w),
  .wrap_ev    (wrap_w),
  .start_ev   (start_w),
  .count      (count_w),
  .period_act (period_act_w),
  .duty_act   (duty_act_w),
  .duty_q     (duty_q)
);

// File: tb/pwm_gen_top_tb.sv
module pwm_gen_top_tb;
  localparam int W     = 32;
  localparam int FLOOR = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   address = '0;
  logic         write = 1'b0;
  logic [W-1:0] writedata = '0;
  logic         read = 1'b0;
  logic [W-1:0] readdata;
  logic         pwm_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_gen_top #(.DATA_W(W), .FLOOR(FLOOR)) u_dut (
    .clk(clk), .rst_n(rst_n), .address(address), .write(write),
    .writedata(writedata), .read(read), .readdata(readdata), .pwm_out(pwm_out)
  );

  // Reference model built from the requirement text.
  logic [W-1:0] m_per, m_duty, m_pa, m_da, m_cnt;
  logic         m_en, m_run;

  function automatic logic [W-1:0] exp_duty(input logic [W-1:0] v);
    if (v < FLOOR) return FLOOR + 1;  // R3
    return v;
  endfunction

  function automatic logic exp_pin(input logic run, input logic [W-1:0] c,
                                   input logic [W-1:0] d);
    if (!run) return 1'b1;            // R4
    return (c <= d) ? 1'b0 : 1'b1;    // R7
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = '0; m_duty = FLOOR + 1; m_en = 1'b0;
      m_run = 1'b0; m_cnt = '0; m_pa = '0; m_da = '0;
    end else begin
      logic [W-1:0] lastc;
      lastc = (m_pa == 0) ? 0 : m_pa - 1;
      if (!m_en) begin
        m_cnt = '0;
      end else if (!m_run || m_cnt >= lastc) begin  // R5, R6, R8
        m_cnt = '0; m_pa = m_per; m_da = m_duty;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_run = m_en;
      if (write) begin
        case (address)
          2'd0: m_per = writedata;
          2'd1: m_duty = exp_duty(writedata);
          2'd2: m_en = writedata[0];
          default: ;
        endcase
      end
    end
  end

  // Pin comparison on every falling edge once out of reset.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e;
      e = exp_pin(m_run, m_cnt, m_da);
      checks++;
      if (pwm_out !== e) begin
        failures++;
        $display("FAIL R7 pin at cycle %0d: actual=%0b expected=%0b", cycles, pwm_out, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    address = a; writedata = d; write = 1'b1;
    @(negedge clk);
    write = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    address = a; read = 1'b1;
    @(negedge clk);
    read = 1'b0;
    checks++;
    if (readdata !== exp) begin
      failures++;
      $display("FAIL %s read ofs %0d: actual=%0d expected=%0d", req, a, readdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (pwm_out !== 1'b1) begin
      failures++;
      $display("FAIL R1 pin: actual=%0b expected=1", pwm_out);
    end
    rd_check(2'd0, 0, "R1");
    rd_check(2'd1, FLOOR + 1, "R1");
    rd_check(2'd2, 0, "R1");
    // R2 readdata zero when rd low
    checks++;
    if (readdata !== '0) begin
      failures++;
      $display("FAIL R2 idle readdata: actual=%0d expected=0", readdata);
    end
    // R3 floor behaviour
    wr_reg(2'd1, 0);         rd_check(2'd1, FLOOR + 1, "R3");
    wr_reg(2'd1, FLOOR - 1); rd_check(2'd1, FLOOR + 1, "R3");
    wr_reg(2'd1, FLOOR);     rd_check(2'd1, FLOOR, "R3");
    wr_reg(2'd1, 7);         rd_check(2'd1, 7, "R3");
    // R2 readback and spare offset
    wr_reg(2'd0, 32'hDEAD_0010); rd_check(2'd0, 32'hDEAD_0010, "R2");
    wr_reg(2'd2, 32'hFFFF_FFFE); rd_check(2'd2, 0, "R2");
    wr_reg(2'd3, 32'h0000_0055);
    rd_check(2'd3, 0, "R2");
    rd_check(2'd0, 32'hDEAD_0010, "R2");
    rd_check(2'd1, 7, "R2");
    rd_check(2'd2, 0, "R2");
    // R4 idle stays high for a while (pin checked every cycle)
    idle(5);
    // R5/R6/R7 directed run: period 10, low-time 4
    wr_reg(2'd0, 10);
    wr_reg(2'd1, 4);
    wr_reg(2'd2, 1);
    rd_check(2'd2, 1, "R2");
    idle(35);
    // R8 mid-cycle changes
    wr_reg(2'd1, 8);
    wr_reg(2'd0, 6);
    idle(25);
    // R6 period 0 behaves as period 1
    wr_reg(2'd0, 0);
    idle(6);
    // duty above period: always low
    wr_reg(2'd0, 5); wr_reg(2'd1, 20);
    idle(12);
    // R4 stop and R5 restart
    wr_reg(2'd2, 0);
    idle(4);
    wr_reg(2'd2, 1);
    idle(10);
    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3)      wr_reg(2'd0, $urandom_range(0, 16));
      else if (op < 6) wr_reg(2'd1, $urandom_range(0, 20));
      else if (op < 7) wr_reg(2'd2, $urandom_range(0, 3));
      else if (op < 8) wr_reg(2'd3, $urandom);
      else if (op < 9) rd_check(2'd1, m_duty, "R2");
      else             rd_check(2'd0, m_per, "R2");
      idle($urandom_range(0, 6));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule